// File: doc/BRIEF.md
# Disk Sector Read Engine with DMA and Interrupt

This block sits on the I/O side of a system and serves one kind of request: reading a disk sector into main memory. Software loads a logical block number and a destination byte address into a small register port, then writes a read command. Storage is treated as a flat run of fixed-size logical blocks numbered from zero. The engine maps the requested block onto a surface, track and sector position for a disk whose geometry is set by parameters.

The engine then pulls the sector contents from a behavioural sector source. It pushes them into memory one 32-bit word per beat over a simple valid/ready write channel, with no processor involvement. When the transfer ends it raises an interrupt line. The line stays high until software clears it. A block number beyond the disk's capacity is reported through an error flag and the same interrupt line, and no memory write takes place.

The default geometry is 512-byte sectors, two surfaces per platter, one platter, eight sectors per track and sixteen tracks, which gives a capacity of 256 blocks.

Top module: `dskdma_engine`

## Requirements
- R1: After reset the status register reads 0, `irq` is low, `dma_valid` is low, and the block-number and destination registers read 0.
- R2: Register offsets on `reg_addr`:
  - 0 is the command register. Writing code 1 in bits [3:0] starts a read.
  - 1 is the logical block number (read/write).
  - 2 is the destination byte address (read/write).
  - 3 is status: bit 0 busy, bit 1 done, bit 2 error. Writing 1 to bit 0 of this register clears done and error.
  - 4 is the latched position: surface in [31:24], track in [23:8], sector in [7:0].
- R3: With S sectors per track and F surfaces in total, a block number L maps to sector = L mod S, surface = (L / S) mod F and track = L / (S·F).
- R4: A read produces exactly SECT_BYTES/4 beats (128 by default). A beat is transferred on a clock edge where `dma_valid` and `dma_ready` are both high. Beat k carries address dest + 4k and data {surface[7:0], track[7:0], sector[7:0], k[7:0]}.
- R5: While `dma_valid` is high and `dma_ready` is low, `dma_valid`, `dma_addr` and `dma_data` hold their values into the next cycle.
- R6: In the cycle after the last beat is transferred, busy is 0, done is 1, `irq` is 1 and `dma_valid` is 0.
- R7: A read command whose block number is at or above the capacity (S·F·tracks) sets error and `irq` in the next cycle, leaves busy at 0, and produces no beat.
- R8: `irq` equals done OR error and stays high until a status clear write. After that write, `irq`, done and error are 0 in the next cycle.
- R9: While busy, writes to the command, block-number and destination registers are ignored. The transfer in flight and the register readback are unaffected.
- R10: A read command that is accepted clears any pending done, error and `irq` in the same edge at which busy rises.
- R11: A command write with any code other than 1 is ignored. Busy stays 0 and no beat is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| dma_valid | output | 1 | Memory write beat offered |
| dma_addr | output | 32 | Byte address of the beat |
| dma_data | output | 32 | Data word of the beat |
| dma_ready | input | 1 | Memory accepts the beat |
| irq | output | 1 | Completion or error interrupt, level |

## Verification
The assertions cover the rules that must hold on every cycle:
- the memory channel holds its beat under back-pressure;
- consecutive accepted beats step the address by four;
- an out-of-range request produces no beat;
- the block-number register stays frozen while busy;
- `irq` stays high until a clear or a new command;
- `irq` is never high while busy;
- the interrupt is present when the channel goes idle.

Only the bench's scenarios can show the rest. The bench sweeps every logical block of the default disk, with and without stalls, and checks the position mapping and the exact word and address of every beat against values it computes itself. Separate scenarios cover refused commands, unknown codes, out-of-range numbers and clearing the interrupt.

// File: rtl/dskdma_pkg.sv
package dskdma_pkg;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_CMD  = 3'd0;
    localparam logic [REG_AW-1:0] RA_LBN  = 3'd1;
    localparam logic [REG_AW-1:0] RA_DEST = 3'd2;
    localparam logic [REG_AW-1:0] RA_STAT = 3'd3;
    localparam logic [REG_AW-1:0] RA_GEO  = 3'd4;

    localparam logic [3:0] CMD_READ = 4'h1;

    typedef enum logic [0:0] {
        MV_IDLE = 1'b0,
        MV_XFER = 1'b1
    } mv_state_e;

    typedef struct packed {
        logic [7:0]  surface;
        logic [15:0] track;
        logic [7:0]  sector;
    } geo_t;

endpackage

// File: rtl/dskdma_xlate.sv
module dskdma_xlate
    import dskdma_pkg::*;
#(
    parameter int unsigned SPT      = 8,
    parameter int unsigned SURFACES = 2
) (
    input  logic [31:0] lbn,
    output geo_t        geo
);
    localparam int unsigned PER_CYL = SPT * SURFACES;

    logic [31:0] sec_w;
    logic [31:0] row_w;
    logic [31:0] surf_w;
    logic [31:0] trk_w;

    always_comb begin
        sec_w  = lbn % 32'(SPT);
        row_w  = lbn / 32'(SPT);
        surf_w = row_w % 32'(SURFACES);
        trk_w  = lbn / 32'(PER_CYL);
        geo.sector  = sec_w[7:0];
        geo.surface = surf_w[7:0];
        geo.track   = trk_w[15:0];
    end

endmodule

// File: rtl/dskdma_srcgen.sv
module dskdma_srcgen (
    input  logic [7:0]  surface,
    input  logic [7:0]  track_lo,
    input  logic [7:0]  sector,
    input  logic [7:0]  beat,
    output logic [31:0] word
);
    always_comb begin
        word = {surface, track_lo, sector, beat};
    end

endmodule

// File: rtl/dskdma_mover.sv
module dskdma_mover
    import dskdma_pkg::*;
#(
    parameter int unsigned BEATS    = 128,
    parameter int unsigned CAPACITY = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] lbn,
    input  logic [31:0] dest,
    input  geo_t        geo_in,
    input  logic        dma_ready,
    output logic        dma_valid,
    output logic [31:0] dma_addr,
    output logic [31:0] dma_data,
    output logic        busy,
    output logic        done_evt,
    output logic        err_evt,
    output geo_t        geo_q
);
    localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

    typedef struct packed {
        mv_state_e    state;
        logic [BW-1:0] beat;
        logic [31:0]  addr;
        geo_t         geo;
    } mv_regs_t;

    mv_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        done_evt = 1'b0;
        err_evt  = 1'b0;
        unique case (r_q.state)
            MV_IDLE: begin
                if (start) begin
                    if (lbn >= 32'(CAPACITY)) begin
                        err_evt = 1'b1;
                    end else begin
                        r_d.state = MV_XFER;
                        r_d.beat  = '0;
                        r_d.addr  = dest;
                        r_d.geo   = geo_in;
                    end
                end
            end
            MV_XFER: begin
                if (dma_ready) begin
                    if (r_q.beat == LAST_BEAT) begin
                        r_d.state = MV_IDLE;
                        done_evt  = 1'b1;
                    end else begin
                        r_d.beat = r_q.beat + 1'b1;
                        r_d.addr = r_q.addr + 32'd4;
                    end
                end
            end
            default: r_d.state = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: MV_IDLE, beat: '0, addr: '0, geo: '0};
        end else begin
            r_q <= r_d;
        end
    end

    dskdma_srcgen u_src (
        .surface  (r_q.geo.surface),
        .track_lo (r_q.geo.track[7:0]),
        .sector   (r_q.geo.sector),
        .beat     (8'(r_q.beat)),
        .word     (dma_data)
    );

    assign dma_valid = (r_q.state == MV_XFER);
    assign dma_addr  = r_q.addr;
    assign busy      = (r_q.state == MV_XFER);
    assign geo_q     = r_q.geo;

    assert_hold_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && !dma_ready |=> dma_valid && $stable(dma_addr) && $stable(dma_data));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && dma_ready && !done_evt |=> dma_valid && (dma_addr == $past(dma_addr) + 32'd4));

    assert_no_beat_on_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> !dma_valid);

endmodule

// File: rtl/dskdma_regs.sv
module dskdma_regs
    import dskdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              done_evt,
    input  logic              err_evt,
    input  geo_t              geo_q,
    output logic              start,
    output logic [31:0]       lbn,
    output logic [31:0]       dest,
    output logic              irq
);
    typedef struct packed {
        logic [31:0] lbn;
        logic [31:0] dest;
        logic        done;
        logic        err;
    } rg_regs_t;

    rg_regs_t r_q, r_d;
    logic     clr_wr;

    always_comb begin
        start  = reg_we && !busy && (reg_addr == RA_CMD) && (reg_wdata[3:0] == CMD_READ);
        clr_wr = reg_we && (reg_addr == RA_STAT) && reg_wdata[0];
        r_d    = r_q;
        if (reg_we && !busy) begin
            if (reg_addr == RA_LBN)  r_d.lbn  = reg_wdata;
            if (reg_addr == RA_DEST) r_d.dest = reg_wdata;
        end
        if (start || clr_wr) begin
            r_d.done = 1'b0;
            r_d.err  = 1'b0;
        end
        if (done_evt) r_d.done = 1'b1;
        if (err_evt)  r_d.err  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_LBN:  reg_rdata = r_q.lbn;
            RA_DEST: reg_rdata = r_q.dest;
            RA_STAT: reg_rdata = {29'd0, r_q.err, r_q.done, busy};
            RA_GEO:  reg_rdata = geo_q;
            default: reg_rdata = 32'd0;
        endcase
    end

    assign lbn  = r_q.lbn;
    assign dest = r_q.dest;
    assign irq  = r_q.done | r_q.err;

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr_wr && !start |=> irq);

    assert_quiet_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq);

    assert_lbn_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lbn) && $stable(dest));

endmodule

// File: rtl/dskdma_engine.sv
module dskdma_engine
    import dskdma_pkg::*;
#(
    parameter int unsigned SECT_BYTES       = 512,
    parameter int unsigned SURF_PER_PLATTER = 2,
    parameter int unsigned PLATTERS         = 1,
    parameter int unsigned SPT              = 8,
    parameter int unsigned TRACKS           = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        dma_valid,
    output logic [31:0] dma_addr,
    output logic [31:0] dma_data,
    input  logic        dma_ready,
    output logic        irq
);
    localparam int unsigned SURFACES = SURF_PER_PLATTER * PLATTERS;
    localparam int unsigned CAPACITY = SPT * SURFACES * TRACKS;
    localparam int unsigned BEATS    = SECT_BYTES / 4;

    logic        start;
    logic        busy;
    logic        done_evt;
    logic        err_evt;
    logic [31:0] lbn;
    logic [31:0] dest;
    geo_t        geo_calc;
    geo_t        geo_q;

    dskdma_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done_evt  (done_evt),
        .err_evt   (err_evt),
        .geo_q     (geo_q),
        .start     (start),
        .lbn       (lbn),
        .dest      (dest),
        .irq       (irq)
    );

    dskdma_xlate #(
        .SPT      (SPT),
        .SURFACES (SURFACES)
    ) u_xlate (
        .lbn (lbn),
        .geo (geo_calc)
    );

    dskdma_mover #(
        .BEATS    (BEATS),
        .CAPACITY (CAPACITY)
    ) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .lbn       (lbn),
        .dest      (dest),
        .geo_in    (geo_calc),
        .dma_ready (dma_ready),
        .dma_valid (dma_valid),
        .dma_addr  (dma_addr),
        .dma_data  (dma_data),
        .busy      (busy),
        .done_evt  (done_evt),
        .err_evt   (err_evt),
        .geo_q     (geo_q)
    );

    assert_irq_at_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_valid) |-> irq);

endmodule

// File: tb/dskdma_engine_bench.sv
module dskdma_engine_bench;

    localparam int SPT   = 8;
    localparam int SURF  = 2;
    localparam int TRK   = 16;
    localparam int CAP   = SPT * SURF * TRK;
    localparam int BEATS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        dma_valid;
    logic [31:0] dma_addr;
    logic [31:0] dma_data;
    logic        dma_ready = 1'b1;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dskdma_engine u_dskdma_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dma_valid (dma_valid),
        .dma_addr  (dma_addr),
        .dma_data  (dma_data),
        .dma_ready (dma_ready),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] exp_geo(input int l);
        int s, f, t;
        s = l % SPT;
        f = (l / SPT) % SURF;
        t = l / (SPT * SURF);
        return {8'(f), 16'(t), 8'(s)};
    endfunction

    task automatic drain(input int l, input logic [31:0] dst, input bit stall);
        logic [31:0] g, v, ed;
        int got, cyc;
        g = exp_geo(l);
        got = 0;
        cyc = 0;
        while (got < BEATS && cyc < 2000) begin
            dma_ready = stall ? ((cyc % 3) != 2) : 1'b1;
            #1;
            if (dma_valid && dma_ready) begin
                ed = {g[31:24], g[15:8], g[7:0], 8'(got)};
                chk(dma_addr == dst + 32'(4 * got) && dma_data == ed,
                    "R4 beat addr/data", dma_data, ed);
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        dma_ready = 1'b1;
        chk(got == BEATS, "R4 beat count", 32'(got), 32'(BEATS));
        rd(3'd3, v);
        chk(v == 32'h2 && irq && !dma_valid, "R6 completion status", {v[30:0], irq}, {31'h2, 1'b1});
        rd(3'd4, v);
        chk(v == g, "R3 latched position", v, g);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] dst;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd3, v); chk(v == 0, "R1 status after reset", v, 0);
        chk(!irq && !dma_valid, "R1 irq/valid after reset", {irq, dma_valid}, 0);
        rd(3'd1, v); chk(v == 0, "R1 lbn after reset", v, 0);

        // R11: unknown command code
        wr(3'd0, 32'h2);
        rd(3'd3, v); chk(v == 0 && !dma_valid, "R11 unknown code ignored", v, 0);

        // R2: readback
        wr(3'd1, 32'd37); wr(3'd2, 32'h8000_0040);
        rd(3'd1, v); chk(v == 37, "R2 lbn readback", v, 37);
        rd(3'd2, v); chk(v == 32'h8000_0040, "R2 dest readback", v, 32'h8000_0040);

        // Full sweep over every logical block (R3, R4, R5, R6, R8)
        for (int l = 0; l < CAP; l++) begin
            dst = 32'h1000_0000 + 32'(l * 1024) + 32'(l % 4) * 4;
            wr(3'd1, 32'(l));
            wr(3'd2, dst);
            wr(3'd0, 32'h1);
            if (l == 0) begin
                rd(3'd3, v); chk(v == 32'h1, "R2 busy bit during read", v, 1);
            end
            drain(l, dst, (l % 2) == 1);
            wr(3'd3, 32'h1);
            rd(3'd3, v);
            chk(v == 0 && !irq, "R8 clear drops irq", {v[30:0], irq}, 0);
        end

        // R9: writes ignored while busy (transfer held by ready low)
        wr(3'd1, 32'd5); wr(3'd2, 32'h2000_0000);
        dma_ready = 1'b0;
        wr(3'd0, 32'h1);
        wr(3'd1, 32'd77); wr(3'd2, 32'h3000_0000); wr(3'd0, 32'h1);
        rd(3'd1, v); chk(v == 5, "R9 lbn frozen while busy", v, 5);
        rd(3'd2, v); chk(v == 32'h2000_0000, "R9 dest frozen while busy", v, 32'h2000_0000);
        drain(5, 32'h2000_0000, 1'b0);

        // R8: irq holds without clear
        repeat (10) @(negedge clk);
        chk(irq == 1'b1, "R8 irq held", {31'd0, irq}, 1);

        // R10: new command clears pending done
        wr(3'd1, 32'd9); wr(3'd0, 32'h1);
        rd(3'd3, v); chk(v == 32'h1 && !irq, "R10 start clears done", {v[30:0], irq}, {31'h1, 1'b0});
        drain(9, 32'h2000_0000, 1'b0);

        // R7: out-of-range numbers
        wr(3'd3, 32'h1);
        wr(3'd1, 32'(CAP)); wr(3'd0, 32'h1);
        rd(3'd3, v); chk(v == 32'h4 && irq, "R7 error at capacity", {v[30:0], irq}, {31'h4, 1'b1});
        chk(!dma_valid, "R7 no beat", {31'd0, dma_valid}, 0);
        repeat (5) @(negedge clk);
        chk(!dma_valid, "R7 still no beat", {31'd0, dma_valid}, 0);
        wr(3'd1, 32'hFFFF_FFFF); wr(3'd0, 32'h1);
        rd(3'd3, v); chk(v == 32'h4 && irq && !dma_valid, "R7 error at max lbn", v, 32'h4);

        // R10: valid start after error clears it
        wr(3'd1, 32'(CAP - 1)); wr(3'd0, 32'h1);
        rd(3'd3, v); chk(v == 32'h1 && !irq, "R10 start clears error", v, 1);
        drain(CAP - 1, 32'h2000_0000, 1'b1);
        wr(3'd3, 32'h1);
        rd(3'd3, v); chk(v == 0 && !irq, "R8 final clear", v, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule